// File: doc/BRIEF.md
# Staged Reset Sequencer for a Transceiver Control Plane

This block decides when the control logic of a network transceiver is held in reset and when it is released. Three sources can start a reset. The first is the power-good level, which is treated as a plain digital input. The second is an asynchronous active-low board pin. The third is a write of 1 to a self-clearing software reset bit in the management control register. Each time reset begins, the block emits a single-cycle strobe that returns the management registers to their default values.

Release takes two stages. The management serial port is declared ready after a short fixed count. The data-path clocks toward the MAC are declared valid only after a long settling interval. The reset cycle ends only at that second point, and the data interface must stay disabled until then. Any new qualifying request restarts the sequence from its beginning. All timing counts are in reference-clock cycles and are set by parameters, so a simulation can shorten the long interval.

Top module: `rst_sequencer`

## Requirements
- R1: While `pwr_good` is low, `mgmt_ready`=0, `clocks_valid`=0, `reset_active`=1, `load_defaults`=0 and `sw_rst_rd`=0.
- R2: After `pwr_good` rises, `load_defaults` is high for one cycle after the 3rd rising clock edge. `mgmt_ready` rises after edge POR_CYCLES+19, with edges counted from the first one after the rise.
- R3: While the power-on hold is running, the pin is not monitored, so a low pulse of any length during that hold does not change the release timing.
- R4: Two flops synchronise the pin. Once synchronised, a low level that lasts MIN_LOW_CYCLES consecutive cycles (default 5) enters pin reset, and `load_defaults` pulses after the 7th edge from the falling pin. A shorter low level has no effect.
- R5: The synchronised pin release is seen two cycles after the pin rises. `mgmt_ready` rises MGMT_CYCLES (default 16) cycles after that, which is after the 19th edge from the rising pin.
- R6: `clocks_valid` rises SETTLE_CYCLES after `mgmt_ready`, in the same cycle that `reset_active` falls. `clocks_valid` is never high while `mgmt_ready` is low.
- R7: A write with `sw_rst_wdata`=1 makes `sw_rst_rd` read 1 for exactly one cycle. On the next cycle reset is entered with a `load_defaults` pulse. `mgmt_ready` then rises after the 18th edge counted from the write edge. A write of 0 has no effect.
- R8: `sw_rst_rd` never shows a pin or power-on reset. Software writes are ignored during the power-on hold and during pin reset.
- R9: A qualifying pin low or a software reset that arrives during either exit stage restarts the whole sequence.
- R10: `load_defaults` is a single-cycle pulse, and it comes with `mgmt_ready`=0 and `clocks_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Supply good level; low holds the whole block in reset |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pin |
| sw_rst_wr | input | 1 | Write strobe for the software reset bit |
| sw_rst_wdata | input | 1 | Value written to the software reset bit |
| sw_rst_rd | output | 1 | Read value of the software reset bit |
| load_defaults | output | 1 | One-cycle strobe that loads register defaults |
| mgmt_ready | output | 1 | Management serial port usable |
| clocks_valid | output | 1 | Transmit/receive clocks valid; data interface enable |
| reset_active | output | 1 | Reset cycle not yet complete |

## Verification
The assertions check on every cycle that the strobe lasts one cycle and never coexists with either ready flag, and that the clocks flag implies management readiness. They also check that the software bit clears itself, that both ready flags rise only from their own exit stage, and that the power-on hold leaves only toward the first exit stage. Exact cycle counts can only be shown by the bench's scenarios. These cover the five-cycle width threshold against a four-cycle pulse, the 16-cycle and settling delays, the insensitivity to the pin during power-on, and restarts that land in the middle of an exit stage.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_POR   = 3'd1,
        S_HOLD  = 3'd2,
        S_EXIT1 = 3'd3,
        S_EXIT2 = 3'd4,
        S_RUN   = 3'd5
    } seq_state_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= RST_VAL;
                else         chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= {STAGES{RST_VAL}};
                else         chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_width_qual.sv
module rstseq_width_qual #(
    parameter int unsigned MIN_LOW_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic watch_en,
    input  logic pin_s,
    output logic qual
);
    localparam int unsigned CW = $clog2(MIN_LOW_CYCLES + 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(MIN_LOW_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(MIN_LOW_CYCLES - 1);

    logic [CW-1:0] low_cnt_d, low_cnt_q;

    always_comb begin
        low_cnt_d = low_cnt_q;
        if (!watch_en || pin_s) low_cnt_d = '0;
        else if (low_cnt_q != CNT_SAT) low_cnt_d = low_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_cnt_q <= '0;
        else        low_cnt_q <= low_cnt_d;
    end

    assign qual = watch_en && !pin_s && (low_cnt_q == CNT_LAST);

    // R4: a qualification needs the pin to have been low on the previous cycle as well
    p_qual_low_history_r4: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> (!pin_s && $past(!pin_s)));
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int unsigned MGMT_CYCLES   = 16,
    parameter int unsigned POR_CYCLES    = 500,
    parameter int unsigned SETTLE_CYCLES = 1325000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_qual,
    input  logic pin_high,
    input  logic sw_wr,
    input  logic sw_wdata,
    output logic watch_en,
    output logic sw_bit,
    output logic load_defaults,
    output logic mgmt_ready,
    output logic clocks_valid,
    output logic reset_active
);
    localparam int unsigned MAX_A = (POR_CYCLES > MGMT_CYCLES) ? POR_CYCLES : MGMT_CYCLES;
    localparam int unsigned MAX_C = (MAX_A > SETTLE_CYCLES) ? MAX_A : SETTLE_CYCLES;
    localparam int unsigned CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] POR_LAST    = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] MGMT_LAST   = CNT_W'(MGMT_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             sw_bit;
        logic             load;
        logic             mgmt;
        logic             cvalid;
        logic             ractive;
    } seq_t;

    seq_t d, q;
    logic sw_req;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        sw_req = sw_wr && sw_wdata && !q.sw_bit &&
                 (q.state == S_EXIT1 || q.state == S_EXIT2 || q.state == S_RUN);

        case (q.state)
            S_OFF: begin
                d.state = S_POR;
                d.cnt   = '0;
                d.load  = 1'b1;
            end
            S_POR: begin
                if (q.cnt == POR_LAST) begin
                    d.state = S_EXIT1;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_HOLD: begin
                if (pin_high) begin
                    d.state = S_EXIT1;
                    d.cnt   = '0;
                end
            end
            S_EXIT1: begin
                if (q.cnt == MGMT_LAST) begin
                    d.state = S_EXIT2;
                    d.cnt   = '0;
                    d.mgmt  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_EXIT2: begin
                if (q.cnt == SETTLE_LAST) begin
                    d.state   = S_RUN;
                    d.cnt     = '0;
                    d.cvalid  = 1'b1;
                    d.ractive = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: ;
        endcase

        // pending software request: enter reset one cycle after the write
        if (q.sw_bit) begin
            d.state   = S_EXIT1;
            d.cnt     = '0;
            d.load    = 1'b1;
            d.mgmt    = 1'b0;
            d.cvalid  = 1'b0;
            d.ractive = 1'b1;
            d.sw_bit  = 1'b0;
        end
        if (sw_req) d.sw_bit = 1'b1;

        // a qualified pin low outranks everything else
        if (pin_qual) begin
            d.state   = S_HOLD;
            d.cnt     = '0;
            d.load    = 1'b1;
            d.mgmt    = 1'b0;
            d.cvalid  = 1'b0;
            d.ractive = 1'b1;
            d.sw_bit  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= S_OFF;
            q.cnt     <= '0;
            q.sw_bit  <= 1'b0;
            q.load    <= 1'b0;
            q.mgmt    <= 1'b0;
            q.cvalid  <= 1'b0;
            q.ractive <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign watch_en      = (q.state != S_OFF) && (q.state != S_POR);
    assign sw_bit        = q.sw_bit;
    assign load_defaults = q.load;
    assign mgmt_ready    = q.mgmt;
    assign clocks_valid  = q.cvalid;
    assign reset_active  = q.ractive;

    // R10: the default-load strobe lasts one cycle
    p_load_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_defaults |=> !load_defaults);
    // R10: the strobe never coexists with either ready flag
    p_load_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_defaults |-> (!mgmt_ready && !clocks_valid));
    // R6: data clocks are never valid before the management port
    p_clk_after_mgmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clocks_valid |-> mgmt_ready);
    // R6: the clocks flag rises together with the end of the reset cycle
    p_clk_ends_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clocks_valid) |-> (!reset_active && $past(q.state) == S_EXIT2));
    // R5: management readiness only appears at the end of the first exit stage
    p_mgmt_from_exit1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mgmt_ready) |-> ($past(q.state) == S_EXIT1));
    // R7: the software bit clears itself after one cycle
    p_sw_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_bit |=> !sw_bit);
    // R3: the power-on hold can only move on to the first exit stage
    p_por_no_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_POR) |=> (q.state == S_POR || q.state == S_EXIT1));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned MIN_LOW_CYCLES = 5,
    parameter int unsigned MGMT_CYCLES    = 16,
    parameter int unsigned POR_CYCLES     = 500,
    parameter int unsigned SETTLE_CYCLES  = 1325000
) (
    input  logic ref_clk,
    input  logic pwr_good,
    input  logic ext_rst_n,
    input  logic sw_rst_wr,
    input  logic sw_rst_wdata,
    output logic sw_rst_rd,
    output logic load_defaults,
    output logic mgmt_ready,
    output logic clocks_valid,
    output logic reset_active
);
    logic por_rst_n;
    logic pin_s;
    logic watch_en;
    logic pin_qual;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
        .clk    (ref_clk),
        .arst_n (pwr_good),
        .d      (1'b1),
        .q      (por_rst_n)
    );

    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk    (ref_clk),
        .arst_n (por_rst_n),
        .d      (ext_rst_n),
        .q      (pin_s)
    );

    rstseq_width_qual #(.MIN_LOW_CYCLES(MIN_LOW_CYCLES)) u_qual (
        .clk      (ref_clk),
        .rst_n    (por_rst_n),
        .watch_en (watch_en),
        .pin_s    (pin_s),
        .qual     (pin_qual)
    );

    rstseq_fsm #(
        .MGMT_CYCLES   (MGMT_CYCLES),
        .POR_CYCLES    (POR_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_fsm (
        .clk           (ref_clk),
        .rst_n         (por_rst_n),
        .pin_qual      (pin_qual),
        .pin_high      (pin_s),
        .sw_wr         (sw_rst_wr),
        .sw_wdata      (sw_rst_wdata),
        .watch_en      (watch_en),
        .sw_bit        (sw_rst_rd),
        .load_defaults (load_defaults),
        .mgmt_ready    (mgmt_ready),
        .clocks_valid  (clocks_valid),
        .reset_active  (reset_active)
    );
endmodule

// File: tb/rst_sequencer_tb.sv
module rst_sequencer_tb;
    localparam int unsigned MINL   = 5;
    localparam int unsigned MGMT   = 16;
    localparam int unsigned POR    = 50;
    localparam int unsigned SETTLE = 200;

    logic clk = 1'b0;
    logic pwr_good, ext_rst_n, sw_wr, sw_wdata;
    logic sw_rd, load_def, mgmt_rdy, clk_valid, rst_act;

    int tests = 0;
    int fails = 0;
    int loads = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    rst_sequencer #(
        .MIN_LOW_CYCLES (MINL),
        .MGMT_CYCLES    (MGMT),
        .POR_CYCLES     (POR),
        .SETTLE_CYCLES  (SETTLE)
    ) u_dut (
        .ref_clk       (clk),
        .pwr_good      (pwr_good),
        .ext_rst_n     (ext_rst_n),
        .sw_rst_wr     (sw_wr),
        .sw_rst_wdata  (sw_wdata),
        .sw_rst_rd     (sw_rd),
        .load_defaults (load_def),
        .mgmt_ready    (mgmt_rdy),
        .clocks_valid  (clk_valid),
        .reset_active  (rst_act)
    );

    always @(negedge clk) if (load_def === 1'b1) loads++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // R1 then R2, R5, R6: power-up sequence
    task automatic t_power_up();
        pwr_good = 1'b0;
        step(4);
        chk("R1", "mgmt_ready off", mgmt_rdy, 1'b0);
        chk("R1", "clocks_valid off", clk_valid, 1'b0);
        chk("R1", "reset_active on", rst_act, 1'b1);
        chk("R1", "load_defaults off", load_def, 1'b0);
        chk("R1", "sw bit off", sw_rd, 1'b0);
        pwr_good = 1'b1;
        step(2);
        chk("R2", "no strobe yet", load_def, 1'b0);
        step(1);
        chk("R2", "strobe after edge 3", load_def, 1'b1);
        step(1);
        chk("R2", "strobe single", load_def, 1'b0);
        step(POR + 18 - 4);
        chk("R2", "mgmt low before edge POR+19", mgmt_rdy, 1'b0);
        step(1);
        chk("R2", "mgmt high at edge POR+19", mgmt_rdy, 1'b1);
        step(SETTLE - 1);
        chk("R6", "clocks not yet valid", clk_valid, 1'b0);
        chk("R6", "still in reset", rst_act, 1'b1);
        step(1);
        chk("R6", "clocks valid", clk_valid, 1'b1);
        chk("R6", "reset over", rst_act, 1'b0);
    endtask

    // R3: pin pulse during the power-on hold has no effect
    task automatic t_por_ignores_pin();
        int l0;
        pwr_good = 1'b0;
        step(3);
        pwr_good = 1'b1;
        l0 = loads;
        step(5);
        ext_rst_n = 1'b0;
        step(20);
        ext_rst_n = 1'b1;
        step(POR + 18 - 25);
        chk("R3", "mgmt low before nominal time", mgmt_rdy, 1'b0);
        step(1);
        chk("R3", "mgmt at nominal power-on time", mgmt_rdy, 1'b1);
        chk_int("R3", "only the power-on strobe", loads - l0, 1);
        step(SETTLE);
        chk("R3", "clocks valid at nominal time", clk_valid, 1'b1);
    endtask

    // R4: a 4-cycle pulse is ignored
    task automatic t_short_pin();
        int l0 = loads;
        ext_rst_n = 1'b0;
        step(MINL - 1);
        ext_rst_n = 1'b1;
        step(30);
        chk_int("R4", "no strobe for short pulse", loads - l0, 0);
        chk("R4", "mgmt kept", mgmt_rdy, 1'b1);
        chk("R4", "clocks kept", clk_valid, 1'b1);
    endtask

    // R4, R5, R6, R8, R10: qualified pin reset and staged release
    task automatic t_pin_reset();
        int l0 = loads;
        ext_rst_n = 1'b0;
        step(6);
        chk("R4", "no strobe after edge 6", load_def, 1'b0);
        chk("R4", "still running", clk_valid, 1'b1);
        step(1);
        chk("R4", "strobe after edge 7", load_def, 1'b1);
        chk("R10", "mgmt dropped with strobe", mgmt_rdy, 1'b0);
        chk("R10", "clocks dropped with strobe", clk_valid, 1'b0);
        chk("R4", "reset active", rst_act, 1'b1);
        step(1);
        chk("R10", "strobe one cycle", load_def, 1'b0);
        chk("R8", "sw bit hides pin reset", sw_rd, 1'b0);
        sw_wr = 1'b1; sw_wdata = 1'b1;
        step(1);
        sw_wr = 1'b0;
        chk("R8", "write ignored in pin reset", sw_rd, 1'b0);
        step(5);
        chk_int("R8", "single strobe during hold", loads - l0, 1);
        ext_rst_n = 1'b1;
        step(18);
        chk("R5", "mgmt low before edge 19", mgmt_rdy, 1'b0);
        step(1);
        chk("R5", "mgmt high at edge 19", mgmt_rdy, 1'b1);
        chk("R6", "clocks not with mgmt", clk_valid, 1'b0);
        step(SETTLE - 1);
        chk("R6", "clocks low before settle end", clk_valid, 1'b0);
        step(1);
        chk("R6", "clocks valid after settle", clk_valid, 1'b1);
        chk("R6", "reset_active cleared", rst_act, 1'b0);
    endtask

    // R7: software reset
    task automatic t_sw_reset();
        int l0 = loads;
        sw_wr = 1'b1; sw_wdata = 1'b0;
        step(1);
        sw_wr = 1'b0;
        step(2);
        chk("R7", "write of 0 ignored", sw_rd, 1'b0);
        chk("R7", "running after write 0", clk_valid, 1'b1);
        chk_int("R7", "no strobe on write 0", loads - l0, 0);
        sw_wr = 1'b1; sw_wdata = 1'b1;
        step(1);
        sw_wr = 1'b0;
        chk("R7", "bit reads 1", sw_rd, 1'b1);
        chk("R7", "no strobe on write edge", load_def, 1'b0);
        step(1);
        chk("R7", "bit self-clears", sw_rd, 1'b0);
        chk("R7", "strobe next cycle", load_def, 1'b1);
        chk("R7", "mgmt dropped", mgmt_rdy, 1'b0);
        step(15);
        chk("R7", "mgmt low before edge 18", mgmt_rdy, 1'b0);
        step(1);
        chk("R7", "mgmt high at edge 18", mgmt_rdy, 1'b1);
        step(SETTLE);
        chk("R7", "clocks valid after settle", clk_valid, 1'b1);
    endtask

    // R9: restarts during exit stages
    task automatic t_restart();
        sw_wr = 1'b1; sw_wdata = 1'b1;
        step(1);
        sw_wr = 1'b0;
        step(10);
        sw_wr = 1'b1; sw_wdata = 1'b1;
        step(1);
        sw_wr = 1'b0;
        step(16);
        chk("R9", "sw restart in stage 1 delays mgmt", mgmt_rdy, 1'b0);
        step(1);
        chk("R9", "mgmt after restarted count", mgmt_rdy, 1'b1);
        step(20);
        ext_rst_n = 1'b0;
        step(7);
        chk("R9", "pin restart in stage 2 strobes", load_def, 1'b1);
        chk("R9", "pin restart drops mgmt", mgmt_rdy, 1'b0);
        step(3);
        ext_rst_n = 1'b1;
        step(18);
        chk("R9", "mgmt low after pin restart", mgmt_rdy, 1'b0);
        step(1);
        chk("R9", "mgmt high after pin restart", mgmt_rdy, 1'b1);
        step(SETTLE);
        chk("R9", "clocks valid after restart", clk_valid, 1'b1);
    endtask

    initial begin
        pwr_good  = 1'b0;
        ext_rst_n = 1'b1;
        sw_wr     = 1'b0;
        sw_wdata  = 1'b0;
        @(negedge clk);
        t_power_up();
        t_por_ignores_pin();
        t_short_pin();
        t_pin_reset();
        t_sw_reset();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule